// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block keeps a 16-bit position count for an incremental encoder that delivers two phase signals, A and B, offset by a quarter period. Both phases are brought into the clock domain through synchronizer chains, and each change of a synchronized phase is a candidate count step. The order in which the phases change decides whether the step counts up or down. As a result the count follows the shaft position at whatever speed the encoder turns.

A 2-bit selector picks the transitions that count, which gives 2x resolution (one phase only) or 4x resolution (both phases). A 3-bit mode input enables the encoder function and picks the interrupt source. One source pulses on every counted step. The other pulses only when the count direction reverses. A direction status output, two sticky flags with clear inputs, a run gate, a direction inversion input and a toggle output round out the block. The toggle output flips on each wrap of the count.

Top module: `qenc_position_counter`

## Requirements
- R1: Counting happens only when `mode` is 3'b110 or 3'b111. Any other mode value leaves the count, direction, flags and toggle output unchanged.
- R2: `trig_sel` picks the counting transitions. 2'b00 counts nothing. 2'b01 counts any change of A only. 2'b10 counts any change of B only. 2'b11 counts any change of either phase.
- R3: A counted A change steps up when A differs from B after the change, and steps down otherwise. A counted B change steps up when A equals B after the change, and steps down otherwise. Each step is exactly +1 or -1 modulo 2^16. The counter wraps in both directions.
- R4: While `run` is low the count holds its value.
- R5: With `mode` 3'b111, `irq` is high for exactly one cycle for every counted step.
- R6: With `mode` 3'b110, `irq` is high for one cycle only on a counted step whose direction differs from the current `dir_up`.
- R7: `dir_up` shows the direction of the most recent counted step (1 = up). It reads 1 after reset.
- R8: `edge_flag` is set by every counted step. `dirchg_flag` is set by every counted step that reverses the direction. Each flag stays set until its clear input is pulsed. A set in the same cycle takes priority over the clear.
- R9: With `dir_invert` high, every step moves the count the opposite way from the rule in R3, and `dir_up` reports the applied direction.
- R10: A sample in which both synchronized phases change together produces no count and no flag or irq.
- R11: `tog_out` inverts on each step from 16'hFFFF to 16'h0000 and on each step from 16'h0000 to 16'hFFFF, and at no other time.
- R12: After reset, the count, both flags, `irq` and `tog_out` are 0. A phase change that is set up before rising edge k shows on `count` after rising edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| mode | input | 3 | 110 = rotation-interrupt mode, 111 = edge-interrupt mode, other = idle |
| trig_sel | input | 2 | Counting transition select |
| run | input | 1 | Count enable |
| dir_invert | input | 1 | Invert the applied direction |
| clr_dirchg | input | 1 | Clear pulse for dirchg_flag |
| clr_edge | input | 1 | Clear pulse for edge_flag |
| count | output | 16 | Position count |
| dir_up | output | 1 | Direction of the last counted step |
| dirchg_flag | output | 1 | Sticky direction-change flag |
| edge_flag | output | 1 | Sticky count-edge flag |
| irq | output | 1 | One-cycle interrupt pulse |
| tog_out | output | 1 | Toggles on counter wrap |

## Verification
A direction rule that is decoded wrongly shows up on the count output two edges after the phase change. It appears as a step the wrong way, or as no step where one was expected. A stale direction register cannot be seen in the count. It does show at the ports, as a missing or extra irq pulse in rotation mode and as a wrong `dir_up`. A wrap that is handled badly shows at once on `tog_out`. The bench therefore walks full quadrature cycles in both directions through zero. It also counts irq pulses at each step, so no irq pulse can go unobserved.

// File: rtl/qenc_pkg.sv
// Package: shared constants for the quadrature position counter.
// Assumes: mode and trigger encodings are fixed by the block's requirements.
package qenc_pkg;
    localparam logic [2:0] MODE_ROTATION = 3'b110;
    localparam logic [2:0] MODE_EDGE     = 3'b111;

    typedef enum logic [1:0] {
        TRIG_NONE = 2'b00,
        TRIG_A    = 2'b01,
        TRIG_B    = 2'b10,
        TRIG_AB   = 2'b11
    } trig_sel_e;

    localparam int PHASES = 2;
endpackage

// File: rtl/qenc_sync_edge.sv
// Module: qenc_sync_edge
// Brings N asynchronous inputs into the clock domain through STAGES flops each,
// then keeps one more sample so that a change between consecutive samples can be
// flagged. Assumes: STAGES >= 2; the inputs are glitch-free at the sample rate.
module qenc_sync_edge #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] level,
    output logic [N-1:0] prev,
    output logic [N-1:0] changed
);
    localparam int LAST = STAGES - 1;

    logic [N-1:0] stage [STAGES];

    // Synchronizer chain; stage 0 takes the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= din;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    // Previous synchronized sample, the reference for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= stage[LAST];
    end

    // Per-input change flags.
    always_comb begin
        level   = stage[LAST];
        changed = stage[LAST] ^ prev;
    end
endmodule

// File: rtl/qenc_decode.sv
// Module: qenc_decode
// Qualifies phase changes against the trigger select and derives the raw step
// direction from the phase levels after the change. A change on both phases
// in one sample is an error and yields no step. Purely combinational.
module qenc_decode
    import qenc_pkg::*;
(
    input  logic       a_lvl,
    input  logic       b_lvl,
    input  logic       a_chg,
    input  logic       b_chg,
    input  logic [1:0] trig_sel,
    output logic       step,
    output logic       step_up,
    output logic       both_err
);
    logic use_a;
    logic use_b;

    // Trigger qualification: which phases may produce a count.
    always_comb begin
        use_a = (trig_sel == TRIG_A) || (trig_sel == TRIG_AB);
        use_b = (trig_sel == TRIG_B) || (trig_sel == TRIG_AB);
    end

    // Step detection and direction rule.
    always_comb begin
        both_err = a_chg && b_chg;
        step     = 1'b0;
        step_up  = 1'b0;
        if (!both_err) begin
            if (a_chg && use_a) begin
                step    = 1'b1;
                step_up = (a_lvl != b_lvl);
            end else if (b_chg && use_b) begin
                step    = 1'b1;
                step_up = (a_lvl == b_lvl);
            end
        end
    end
endmodule

// File: rtl/qenc_counter.sv
// Module: qenc_counter
// Holds the position count, applied direction, sticky flags, interrupt pulse
// and wrap toggle. Assumes: step is a one-cycle qualifier already gated by
// mode and run; dir_in is the direction after inversion.
module qenc_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             dir_in,
    input  logic             irq_on_edge,
    input  logic             clr_dirchg,
    input  logic             clr_edge,
    output logic [WIDTH-1:0] count,
    output logic             dir_up,
    output logic             dirchg_flag,
    output logic             edge_flag,
    output logic             irq,
    output logic             tog_out
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO     = '0;

    logic reversal;
    logic wrap;

    // Reversal and wrap detection for the step being applied.
    always_comb begin
        reversal = step && (dir_in != dir_up);
        wrap     = step && ((dir_in && count == ALL_ONES) ||
                            (!dir_in && count == ZERO));
    end

    // Position count and applied direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            dir_up <= 1'b1;
        end else if (step) begin
            count  <= dir_in ? count + 1'b1 : count - 1'b1;
            dir_up <= dir_in;
        end
    end

    // Sticky flags; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_flag   <= 1'b0;
            dirchg_flag <= 1'b0;
        end else begin
            if (step)            edge_flag <= 1'b1;
            else if (clr_edge)   edge_flag <= 1'b0;
            if (reversal)        dirchg_flag <= 1'b1;
            else if (clr_dirchg) dirchg_flag <= 1'b0;
        end
    end

    // One-cycle interrupt pulse from the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_on_edge ? step : reversal;
    end

    // Wrap toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)    tog_out <= 1'b0;
        else if (wrap) tog_out <= ~tog_out;
    end
endmodule

// File: rtl/qenc_position_counter.sv
// Module: qenc_position_counter (top)
// Quadrature encoder position counter: synchronizes both phases, qualifies and
// decodes steps, and keeps count, status and interrupt. Assumes: phase inputs
// are asynchronous and change at most once per synchronized sample per phase.
module qenc_position_counter
    import qenc_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic [2:0]       mode,
    input  logic [1:0]       trig_sel,
    input  logic             run,
    input  logic             dir_invert,
    input  logic             clr_dirchg,
    input  logic             clr_edge,
    output logic [WIDTH-1:0] count,
    output logic             dir_up,
    output logic             dirchg_flag,
    output logic             edge_flag,
    output logic             irq,
    output logic             tog_out
);
    logic [PHASES-1:0] lvl;
    logic [PHASES-1:0] prv;
    logic [PHASES-1:0] chg;
    logic              raw_step;
    logic              raw_up;
    logic              both_err;
    logic              active;
    logic              step;

    qenc_sync_edge #(.N(PHASES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     ({phase_b, phase_a}),
        .level   (lvl),
        .prev    (prv),
        .changed (chg)
    );

    qenc_decode u_decode (
        .a_lvl    (lvl[0]),
        .b_lvl    (lvl[1]),
        .a_chg    (chg[0]),
        .b_chg    (chg[1]),
        .trig_sel (trig_sel),
        .step     (raw_step),
        .step_up  (raw_up),
        .both_err (both_err)
    );

    // Gate steps by encoder mode and run.
    always_comb begin
        active = (mode == MODE_ROTATION) || (mode == MODE_EDGE);
        step   = raw_step && active && run;
    end

    qenc_counter #(.WIDTH(WIDTH)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .dir_in      (raw_up ^ dir_invert),
        .irq_on_edge (mode == MODE_EDGE),
        .clr_dirchg  (clr_dirchg),
        .clr_edge    (clr_edge),
        .count       (count),
        .dir_up      (dir_up),
        .dirchg_flag (dirchg_flag),
        .edge_flag   (edge_flag),
        .irq         (irq),
        .tog_out     (tog_out)
    );
endmodule

// File: rtl/qenc_position_counter_checks.sv
// Module: qenc_position_counter_checks
// Property checker bound to the top module; observes ports only.
module qenc_position_counter_checks #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [WIDTH-1:0] count,
    input logic             dir_up,
    input logic             edge_flag,
    input logic             irq,
    input logic             tog_out
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    // R3: the count moves by at most one per cycle
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count == $past(count) || count == $past(count) + 1'b1 ||
                          count == $past(count) - 1'b1));

    // R4: a low run leaves the count unchanged
    a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run)) |-> count == $past(count));

    // R8: every interrupt comes with a step, so the edge flag is set
    a_r8_irq_sets_edge: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> edge_flag);

    // R7: direction only changes together with a step
    a_r7_dir_with_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dir_up != $past(dir_up)) |-> count != $past(count));

    // R11: toggle flips only on a wrap
    a_r11_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && tog_out != $past(tog_out)) |->
        ((count == '0 && $past(count) == ALL_ONES) ||
         (count == ALL_ONES && $past(count) == '0)));
endmodule

bind qenc_position_counter qenc_position_counter_checks #(.WIDTH(WIDTH)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .count     (count),
    .dir_up    (dir_up),
    .edge_flag (edge_flag),
    .irq       (irq),
    .tog_out   (tog_out)
);

// File: tb/qenc_position_counter_bench.sv
module qenc_position_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_a = 1'b0;
    logic        phase_b = 1'b0;
    logic [2:0]  mode = 3'b111;
    logic [1:0]  trig_sel = 2'b11;
    logic        run = 1'b1;
    logic        dir_invert = 1'b0;
    logic        clr_dirchg = 1'b0;
    logic        clr_edge = 1'b0;
    logic [15:0] count;
    logic        dir_up, dirchg_flag, edge_flag, irq, tog_out;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    qenc_position_counter u_qenc_position_counter (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
        .mode(mode), .trig_sel(trig_sel), .run(run), .dir_invert(dir_invert),
        .clr_dirchg(clr_dirchg), .clr_edge(clr_edge), .count(count),
        .dir_up(dir_up), .dirchg_flag(dirchg_flag), .edge_flag(edge_flag),
        .irq(irq), .tog_out(tog_out)
    );

    // irq is a one-cycle pulse, seen exactly once at a falling edge
    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    // Vector table: {A, B, expected count, expected dir_up} per step, edge mode, 4x
    localparam int NV = 10;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'd1,      1'b1},
        {1'b1, 1'b1, 16'd2,      1'b1},
        {1'b0, 1'b1, 16'd3,      1'b1},
        {1'b0, 1'b0, 16'd4,      1'b1},
        {1'b0, 1'b1, 16'd3,      1'b0},
        {1'b1, 1'b1, 16'd2,      1'b0},
        {1'b1, 1'b0, 16'd1,      1'b0},
        {1'b0, 1'b0, 16'd0,      1'b0},
        {1'b0, 1'b1, 16'hFFFF,   1'b0},
        {1'b0, 1'b0, 16'd0,      1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive phases at a falling edge and let the change settle through the pipeline
    task automatic drive(input logic a, input logic b);
        @(negedge clk);
        phase_a = a;
        phase_b = b;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        phase_a = 1'b0;
        phase_b = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int i0;
        int c0;
        do_reset();
        // R12: reset state
        check("R12 count", count, 0);
        check("R12 flags", {edge_flag, dirchg_flag, irq, tog_out}, 0);
        check("R7 dir after reset", dir_up, 1);

        // R12: latency, change set before edge k appears after edge k+2
        @(negedge clk);
        phase_a = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R12 not yet", count, 0);
        @(posedge clk); @(negedge clk);
        check("R12 at k+2", count, 1);
        drive(1'b0, 1'b0);   // back down to 0

        // Vector walk, edge interrupt mode
        do_reset();
        for (int i = 0; i < NV; i++) begin
            i0 = irq_cnt;
            drive(VEC[i][18], VEC[i][17]);
            check("R3 count", count, VEC[i][16:1]);
            check("R7 dir", dir_up, VEC[i][0]);
            check("R5 irq per step", irq_cnt - i0, 1);
        end
        // R11: two wraps (0->FFFF, FFFF->0) leave toggle at 0; one more wrap
        check("R11 toggle after two wraps", tog_out, 0);
        drive(1'b0, 1'b1);
        check("R11 toggle after wrap down", tog_out, 1);
        check("R8 dirchg set", dirchg_flag, 1);

        // R8: clear flags
        @(negedge clk); clr_edge = 1'b1; clr_dirchg = 1'b1;
        @(negedge clk); clr_edge = 1'b0; clr_dirchg = 1'b0;
        check("R8 cleared", {edge_flag, dirchg_flag}, 0);
        drive(1'b1, 1'b1);   // down, no reversal
        check("R8 edge set, no dirchg", {edge_flag, dirchg_flag}, 2'b10);

        // R6: rotation mode irq only on reversal
        do_reset();
        mode = 3'b110;
        i0 = irq_cnt;
        drive(1'b1, 1'b0);   // up, no reversal from reset up
        drive(1'b1, 1'b1);   // up
        check("R6 no irq same dir", irq_cnt - i0, 0);
        drive(1'b1, 1'b0);   // down: reversal
        check("R6 irq on reversal", irq_cnt - i0, 1);
        check("R6 count", count, 1);
        mode = 3'b111;

        // R2: A only, B changes ignored
        do_reset();
        trig_sel = 2'b01;
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        check("R2 A only", count, 1);
        trig_sel = 2'b10;
        drive(1'b0, 1'b1);   // A change ignored
        drive(1'b0, 1'b0);   // B change: A==B -> up
        check("R2 B only", count, 2);
        trig_sel = 2'b00;
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        check("R2 none", count, 2);
        trig_sel = 2'b11;

        // R4: run low holds; R1: idle mode holds
        do_reset();
        run = 1'b0;
        drive(1'b1, 1'b0);
        check("R4 hold", count, 0);
        run = 1'b1;
        mode = 3'b010;
        c0 = irq_cnt;
        drive(1'b1, 1'b1);
        check("R1 idle mode", {count, edge_flag, tog_out}, 0);
        check("R1 no irq", irq_cnt - c0, 0);
        mode = 3'b110;
        drive(1'b0, 1'b1);   // active again: up
        check("R1 rotation mode counts", count, 1);
        mode = 3'b111;

        // R9: inversion
        do_reset();
        dir_invert = 1'b1;
        drive(1'b1, 1'b0);
        check("R9 inverted count", count, 16'hFFFF);
        check("R9 dir_up", dir_up, 0);
        check("R11 toggle on inverted wrap", tog_out, 1);
        dir_invert = 1'b0;

        // R10: both phases change together
        do_reset();
        drive(1'b1, 1'b1);
        check("R10 no count", {count, edge_flag}, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule